// File: doc/BRIEF.md
# Memory Clock Power-Down and Turnaround Guard

This block sits between the internal memory-request sequencer and the external memory pins. It has two jobs. The first is to drop the clock-enable and clock-run outputs of a group of synchronous memory banks while no bank in that group is busy. The second is to keep the byte-select/DQM lines quiet for a minimum number of cycles whenever traffic switches between the static domain and the DRAM domain. The static domain covers SRAM and variable-latency I/O. The DRAM domain covers a normal DRAM access, a CAS-before-RAS refresh, and entry into self-refresh.

There are 2*NUM_PAIRS DRAM banks, organised in pairs. Each pair has one gated output group. One more group serves the synchronous mask ROM banks. Two configuration bits control the gating. One lets the clock enables drop when idle. The other, independent of the first, lets the clocks stop when idle. The sequencer raises a bank's activity flag at least one cycle before it issues a command to that bank. The gated outputs are registered, so the group is running again before the command goes out.

On the guard side, the sequencer presents one request strobe and holds it until `stall` is low. A request is accepted in any cycle where it is present and `stall` is low.

Top module: `mem_pwr_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every bit of `grp_cke` and `grp_clk_on` is 1 and `stall` is 0.
- R2: When `cfg_cke_apd` was 0 in the previous cycle, every bit of `grp_cke` is 1, whatever the activity flags are.
- R3: When `cfg_cke_apd` was 1 in the previous cycle, `grp_cke[g]` equals the OR of the flags group g served in the previous cycle. Group g < NUM_PAIRS serves `dram_bank_act[2g]` and `dram_bank_act[2g+1]`. Group NUM_PAIRS serves all bits of `rom_bank_act`. A flag change is therefore not visible on the output in the same cycle.
- R4: When `cfg_clk_apd` was 0 in the previous cycle, every bit of `grp_clk_on` is 1.
- R5: When `cfg_clk_apd` was 1 in the previous cycle, `grp_clk_on[g]` follows the same one-cycle-late group activity as R3. This holds independently of `cfg_cke_apd`.
- R6: `req_static` is a static-domain request. `req_dram`, `req_refresh` and `req_selfref` are each DRAM-domain requests and behave identically for the guard.
- R7: A request in the domain other than that of the last accepted request stalls until at least GAP_CYCLES (default 3) cycles with no accepted request have passed since that last acceptance. If d idle cycles precede the request, it sees max(0, GAP_CYCLES-d) stall cycles.
- R8: A request in the same domain as the last accepted request never stalls, regardless of how little idle time separates them.
- R9: The first request after reset is not stalled.
- R10: `stall` is 0 in any cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cke_apd | input | 1 | Allow idle groups to drop clock enable |
| cfg_clk_apd | input | 1 | Allow idle groups to stop their clock |
| dram_bank_act | input | 2*NUM_PAIRS | Per-bank DRAM activity flags |
| rom_bank_act | input | NUM_ROM_BANKS | Per-bank synchronous ROM activity flags |
| req_static | input | 1 | SRAM / variable-latency I/O request |
| req_dram | input | 1 | DRAM access request |
| req_refresh | input | 1 | CAS-before-RAS refresh request |
| req_selfref | input | 1 | Self-refresh entry request |
| grp_cke | output | NUM_PAIRS+1 | Gated clock enable per group |
| grp_clk_on | output | NUM_PAIRS+1 | Clock-run enable per group |
| stall | output | 1 | Hold the pending request |

## Verification
The checks assume that at most one of the four request strobes is high in any cycle. They also assume that a stalled request stays asserted, in the same domain, until it is accepted. The bench drives one strobe at a time and holds it through every stall cycle. The gating checks also rely on activity flags changing only between clock edges. The bench therefore drives flags and configuration at the falling edge and samples the outputs both before and after the next rising edge.

// File: rtl/mpg_pkg.sv
`timescale 1ns/1ps
package mpg_pkg;
  typedef enum logic [1:0] {
    DOM_NONE   = 2'd0,
    DOM_STATIC = 2'd1,
    DOM_DRAM   = 2'd2
  } dom_e;
endpackage

// File: rtl/mpg_apd_gate.sv
`timescale 1ns/1ps
// One gated clock-enable / clock-run pair serving NSRC bank flags.
module mpg_apd_gate #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            apd_cke,
  input  logic            apd_clk,
  input  logic [NSRC-1:0] act,
  output logic            cke,
  output logic            clk_on
);
  logic busy;
  assign busy = |act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke    <= 1'b1;
      clk_on <= 1'b1;
    end else begin
      cke    <= !apd_cke || busy;
      clk_on <= !apd_clk || busy;
    end
  end
endmodule

// File: rtl/mpg_dom_class.sv
`timescale 1ns/1ps
// Maps the request strobes onto the two turnaround domains.
module mpg_dom_class
  import mpg_pkg::*;
(
  input  logic req_static,
  input  logic req_dram,
  input  logic req_refresh,
  input  logic req_selfref,
  output dom_e dom
);
  logic dram_any;
  assign dram_any = req_dram || req_refresh || req_selfref;

  always_comb begin
    if (req_static)    dom = DOM_STATIC;
    else if (dram_any) dom = DOM_DRAM;
    else               dom = DOM_NONE;
  end
endmodule

// File: rtl/mpg_turn_guard.sv
`timescale 1ns/1ps
// Counts idle cycles since the last accepted request and holds off
// a request that would switch domain too early.
module mpg_turn_guard
  import mpg_pkg::*;
#(
  parameter int GAP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  dom_e req_dom,
  output logic stall
);
  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(GAP_CYCLES);

  dom_e             last_dom;
  logic [CNT_W-1:0] idle_cnt;
  logic             have_req;
  logic             switching;
  logic             accept;

  assign have_req  = (req_dom != DOM_NONE);
  assign switching = have_req && (last_dom != DOM_NONE) && (req_dom != last_dom);
  assign stall     = switching && (idle_cnt < GAP_MAX);
  assign accept    = have_req && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_dom <= DOM_NONE;
      idle_cnt <= GAP_MAX;
    end else if (accept) begin
      last_dom <= req_dom;
      idle_cnt <= '0;
    end else if (idle_cnt < GAP_MAX) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mem_pwr_guard.sv
`timescale 1ns/1ps
module mem_pwr_guard
  import mpg_pkg::*;
#(
  parameter int NUM_PAIRS     = 2,
  parameter int NUM_ROM_BANKS = 4,
  parameter int GAP_CYCLES    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_cke_apd,
  input  logic                   cfg_clk_apd,
  input  logic [2*NUM_PAIRS-1:0] dram_bank_act,
  input  logic [NUM_ROM_BANKS-1:0] rom_bank_act,
  input  logic                   req_static,
  input  logic                   req_dram,
  input  logic                   req_refresh,
  input  logic                   req_selfref,
  output logic [NUM_PAIRS:0]     grp_cke,
  output logic [NUM_PAIRS:0]     grp_clk_on,
  output logic                   stall
);
  localparam int NGRP = NUM_PAIRS + 1;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      if (g < NUM_PAIRS) begin : g_pair
        mpg_apd_gate #(.NSRC(2)) i_gate (
          .clk    (clk),
          .rst    (rst),
          .apd_cke(cfg_cke_apd),
          .apd_clk(cfg_clk_apd),
          .act    (dram_bank_act[2*g+1:2*g]),
          .cke    (grp_cke[g]),
          .clk_on (grp_clk_on[g])
        );
      end else begin : g_rom
        mpg_apd_gate #(.NSRC(NUM_ROM_BANKS)) i_gate (
          .clk    (clk),
          .rst    (rst),
          .apd_cke(cfg_cke_apd),
          .apd_clk(cfg_clk_apd),
          .act    (rom_bank_act),
          .cke    (grp_cke[g]),
          .clk_on (grp_clk_on[g])
        );
      end
    end
  endgenerate

  dom_e req_dom;

  mpg_dom_class i_class (
    .req_static (req_static),
    .req_dram   (req_dram),
    .req_refresh(req_refresh),
    .req_selfref(req_selfref),
    .dom        (req_dom)
  );

  mpg_turn_guard #(.GAP_CYCLES(GAP_CYCLES)) i_guard (
    .clk    (clk),
    .rst    (rst),
    .req_dom(req_dom),
    .stall  (stall)
  );
endmodule

// File: rtl/mem_pwr_guard_chk.sv
`timescale 1ns/1ps
module mem_pwr_guard_chk #(
  parameter int NUM_PAIRS     = 2,
  parameter int NUM_ROM_BANKS = 4,
  parameter int GAP_CYCLES    = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_cke_apd,
  input logic                     cfg_clk_apd,
  input logic [2*NUM_PAIRS-1:0]   dram_bank_act,
  input logic [NUM_ROM_BANKS-1:0] rom_bank_act,
  input logic                     req_static,
  input logic                     req_dram,
  input logic                     req_refresh,
  input logic                     req_selfref,
  input logic [NUM_PAIRS:0]       grp_cke,
  input logic [NUM_PAIRS:0]       grp_clk_on,
  input logic                     stall
);
  localparam int NGRP = NUM_PAIRS + 1;

  logic [NGRP-1:0] busy;
  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_busy
      if (g < NUM_PAIRS) begin : g_p
        assign busy[g] = dram_bank_act[2*g] || dram_bank_act[2*g+1];
      end else begin : g_r
        assign busy[g] = |rom_bank_act;
      end
    end
  endgenerate

  logic dram_req, any_req;
  assign dram_req = req_dram || req_refresh || req_selfref;
  assign any_req  = req_static || dram_req;

  // Checker-side model of the last accepted domain: 0 none, 1 static, 2 dram
  logic [1:0] seen_dom, req_code;
  logic [7:0] stall_run;
  assign req_code = req_static ? 2'd1 : (dram_req ? 2'd2 : 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_dom  <= 2'd0;
      stall_run <= '0;
    end else begin
      if (any_req && !stall) seen_dom <= req_code;
      if (stall) stall_run <= (stall_run == 8'hff) ? stall_run : stall_run + 1'b1;
      else       stall_run <= '0;
    end
  end

  p_reset_outputs_r1: assert property (@(posedge clk)
    $past(rst) |-> (&grp_cke && &grp_clk_on && !stall));

  p_cke_held_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_cke_apd) |-> &grp_cke);

  p_clk_held_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_clk_apd) |-> &grp_clk_on);

  generate
    for (g = 0; g < NGRP; g++) begin : g_trk
      p_cke_track_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cfg_cke_apd)) |-> (grp_cke[g] == $past(busy[g])));
      p_clk_track_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cfg_clk_apd)) |-> (grp_clk_on[g] == $past(busy[g])));
    end
  endgenerate

  // Input contract: one request class at a time (R6)
  p_one_req_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({req_static, req_dram, req_refresh, req_selfref}) <= 1);

  p_stall_bound_r7: assert property (@(posedge clk) disable iff (rst)
    stall |-> (stall_run < 8'(GAP_CYCLES)));

  p_same_dom_r8: assert property (@(posedge clk) disable iff (rst)
    (any_req && seen_dom == req_code) |-> !stall);

  p_first_free_r9: assert property (@(posedge clk) disable iff (rst)
    (seen_dom == 2'd0) |-> !stall);

  p_idle_nostall_r10: assert property (@(posedge clk) disable iff (rst)
    !any_req |-> !stall);
endmodule

bind mem_pwr_guard mem_pwr_guard_chk #(
  .NUM_PAIRS    (NUM_PAIRS),
  .NUM_ROM_BANKS(NUM_ROM_BANKS),
  .GAP_CYCLES   (GAP_CYCLES)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_cke_apd  (cfg_cke_apd),
  .cfg_clk_apd  (cfg_clk_apd),
  .dram_bank_act(dram_bank_act),
  .rom_bank_act (rom_bank_act),
  .req_static   (req_static),
  .req_dram     (req_dram),
  .req_refresh  (req_refresh),
  .req_selfref  (req_selfref),
  .grp_cke      (grp_cke),
  .grp_clk_on   (grp_clk_on),
  .stall        (stall)
);

// File: tb/test_mem_pwr_guard.sv
`timescale 1ns/1ps
module test_mem_pwr_guard;
  localparam int NP  = 2;
  localparam int NR  = 4;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cke_apd = 1'b0, cfg_clk_apd = 1'b0;
  logic [2*NP-1:0] dram_bank_act = '0;
  logic [NR-1:0]   rom_bank_act  = '0;
  logic req_static = 1'b0, req_dram = 1'b0, req_refresh = 1'b0, req_selfref = 1'b0;
  logic [NP:0] grp_cke, grp_clk_on;
  logic stall;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mem_pwr_guard #(.NUM_PAIRS(NP), .NUM_ROM_BANKS(NR), .GAP_CYCLES(GAP)) i_mem_pwr_guard (
    .clk(clk), .rst(rst), .cfg_cke_apd(cfg_cke_apd), .cfg_clk_apd(cfg_clk_apd),
    .dram_bank_act(dram_bank_act), .rom_bank_act(rom_bank_act),
    .req_static(req_static), .req_dram(req_dram), .req_refresh(req_refresh),
    .req_selfref(req_selfref), .grp_cke(grp_cke), .grp_clk_on(grp_clk_on), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_req(input int kind);
    req_static  = (kind == 0);
    req_dram    = (kind == 1);
    req_refresh = (kind == 2);
    req_selfref = (kind == 3);
  endtask

  function automatic logic [NP:0] grp_busy(input logic [7:0] p);
    logic [NP:0] b;
    for (int g = 0; g < NP; g++) b[g] = p[2*g] | p[2*g+1];
    b[NP] = |p[7:4];
    return b;
  endfunction

  // kind 0 = static; kinds 1..3 (access, refresh, self-refresh) = DRAM (R6)
  task automatic run_gap(input int a, input int b, input int d);
    int cnt;
    int exp;
    repeat (GAP + 2) begin
      @(negedge clk); drive_req(-1); #1;
      check(stall == 1'b0, "R10 idle", int'(stall), 0);
    end
    @(negedge clk); drive_req(a); #1;
    check(stall == 1'b0, "R7 after long idle", int'(stall), 0);
    repeat (d) begin
      @(negedge clk); drive_req(-1);
    end
    @(negedge clk); drive_req(b);
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (!stall) break;
      cnt++;
      @(negedge clk);
    end
    if ((a == 0) != (b == 0)) begin
      exp = (GAP - d > 0) ? GAP - d : 0;
      check(cnt == exp, "R7 cross-domain stall count", cnt, exp);
    end else begin
      check(cnt == 0, "R8 same-domain stall count", cnt, 0);
    end
    @(negedge clk); drive_req(-1);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    logic [NP:0] prev_cke, prev_clk, bz;
    // R1: reset state, even with both power-down bits set and idle banks
    cfg_cke_apd = 1'b1; cfg_clk_apd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(&grp_cke, "R1 cke in reset", int'(grp_cke), (1 << (NP+1)) - 1);
    check(&grp_clk_on, "R1 clk in reset", int'(grp_clk_on), (1 << (NP+1)) - 1);
    check(stall == 1'b0, "R1 stall in reset", int'(stall), 0);
    rst = 1'b0;
    #1;
    check(&grp_cke && &grp_clk_on, "R1 outputs before first edge", int'(grp_cke), (1 << (NP+1)) - 1);

    // R9: first request after reset, then an immediate switch (R7)
    @(negedge clk); drive_req(1); #1;
    check(stall == 1'b0, "R9 first request", int'(stall), 0);
    @(negedge clk); drive_req(0); #1;
    check(stall == 1'b1, "R7 immediate switch stalls", int'(stall), 1);
    @(negedge clk); drive_req(-1);

    // R6/R7/R8: all domain pairs over idle lead-ins 0..GAP+1
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d <= GAP + 1; d++)
          run_gap(a, b, d);

    // R2..R5: exhaustive sweep of config bits and activity flags
    @(negedge clk);
    prev_cke = grp_cke;
    prev_clk = grp_clk_on;
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        cfg_cke_apd = c[0];
        cfg_clk_apd = c[1];
        dram_bank_act = p[3:0];
        rom_bank_act  = p[7:4];
        #1;
        check(grp_cke == prev_cke, "R3 cke holds until edge", int'(grp_cke), int'(prev_cke));
        check(grp_clk_on == prev_clk, "R5 clk holds until edge", int'(grp_clk_on), int'(prev_clk));
        bz = grp_busy(8'(p));
        prev_cke = c[0] ? bz : '1;
        prev_clk = c[1] ? bz : '1;
        @(negedge clk);
        if (c[0]) check(grp_cke == prev_cke, "R3 cke tracks activity", int'(grp_cke), int'(prev_cke));
        else      check(grp_cke == prev_cke, "R2 cke held on", int'(grp_cke), int'(prev_cke));
        if (c[1]) check(grp_clk_on == prev_clk, "R5 clk tracks activity", int'(grp_clk_on), int'(prev_clk));
        else      check(grp_clk_on == prev_clk, "R4 clk held on", int'(grp_clk_on), int'(prev_clk));
      end
    end
    finish_up();
  end
endmodule